// File: doc/BRIEF.md
# DRAM Wake-Up Sequencer

This block decides how a DDR memory controller brings its DRAM back into service. A configuration write carries a two-bit wake-mode field and an init-request bit. The block reads them and runs one of two paths. The cold path is a full power-up initialization: a clock-enable hold, precharges, refreshes and mode-register loads. The warm path only takes the DRAM out of self-refresh, and the contents held in the DRAM survive. The block drives the clock-enable (CKE) level and raises one command request at a time on a valid/acknowledge command interface. A downstream command engine turns each request into DRAM bus cycles.

Once either path completes, `ready` goes high and normal traffic may flow. While `ready` is high, the controller can place the DRAM in self-refresh for idle or throttling periods and later bring it back. A wake-up is then always a bare self-refresh exit. After the first self-refresh exit has completed, a wake-mode field with its upper bit set is ignored until hardware reset. Periodic self-refresh cycles therefore never re-initialize the DRAM, and they never load its mode registers again.

States: `ST_IDLE` (after reset, CKE low), `ST_STAB` (CKE held low for the stabilization count), `ST_PRE_A`, `ST_EMRS`, `ST_MRS_DLL`, `ST_PRE_B`, `ST_REF_A`, `ST_REF_B`, `ST_MRS_RUN` (cold command steps), `ST_READY`, `ST_SR_ENTER` (self-refresh entry command), `ST_SR_HOLD` (in self-refresh, CKE low), `ST_XWAIT` (CKE high, exit-latency count), `ST_XREF` (exit refresh).

Transitions:
- `ST_IDLE` goes to `ST_STAB` on a cold trigger, or to `ST_XWAIT` on an accepted warm write.
- `ST_STAB` goes to `ST_PRE_A` when the count expires.
- Each command state advances on acknowledge. The order is `ST_PRE_A`, `ST_EMRS`, `ST_MRS_DLL`, `ST_PRE_B`, `ST_REF_A`, `ST_REF_B`, `ST_MRS_RUN`, and then `ST_READY`.
- `ST_READY` goes to `ST_STAB` on a cold trigger, or to `ST_SR_ENTER` on `sr_enter_req`.
- `ST_SR_ENTER` goes to `ST_SR_HOLD` on acknowledge.
- `ST_SR_HOLD` goes to `ST_XWAIT` on `sr_exit_req` or on an accepted warm write.
- `ST_XWAIT` goes to `ST_XREF` when the count expires.
- `ST_XREF` goes to `ST_READY` on acknowledge.

Top module: `dram_wake_seq`

## Requirements
- R1: After reset, `cke`, `ready` and `cmd_valid` are all 0.
- R2: A cold start is triggered only by a write with `cfg_mode`=2'b01 and `cfg_init`=1 together. A write with `cfg_init`=1 and `cfg_mode`=2'b00 starts nothing. A write with `cfg_mode`=2'b01 and `cfg_init`=0 also starts nothing. With `cfg_mode[1]`=1, `cfg_init` plays no part.
- R3: On a cold start, `cke` stays low for exactly `stab_cycles`+1 cycles after the accepting edge. `cke` then rises in the same cycle as the first request.
- R4: The cold requests come in this order:
  - PRE
  - EMRS
  - MRS with `cmd_dll_rst`=1
  - PRE
  - REF
  - REF
  - MRS with `cmd_dll_rst`=0

  The `cmd_op` encodings are PRE=0, REF=1, MRS=2, EMRS=3 and SRE=4. Every request is made with `cke` high.
- R5: A write with `cfg_mode[1]`=1, accepted in `ST_IDLE` or `ST_SR_HOLD` before the first completed exit, starts the warm exit. `cke` rises at once and is held for `exit_cycles`+1 cycles with no request. A single REF request follows, and then `ready` goes high. No mode-register load is issued on this path.
- R6: A request with `cmd_ack` low is held on the next cycle with the same `cmd_op` and `cmd_dll_rst`.
- R7: `ready` is high only after a path has completed, and `ready` implies `cke` high.
- R8: `sr_enter_req` in `ST_READY` issues one SRE request. After it is acknowledged, `cke` and `ready` are both low.
- R9: `sr_exit_req` in `ST_SR_HOLD` runs the warm exit protocol of R5 and never the cold sequence.
- R10: After the first warm exit completes, writes with `cfg_mode[1]`=1 are ignored until reset. `cke` stays low and no request appears.
- R11: A cold trigger accepted in `ST_READY` drops `cke`, reruns the full cold sequence and clears `ready` until it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Wake-mode field: 01 cold, 1x warm |
| cfg_init | input | 1 | Init-request bit in the same write |
| stab_cycles | input | CNT_W | Cold CKE-low hold count |
| exit_cycles | input | CNT_W | Self-refresh exit latency count |
| sr_enter_req | input | 1 | Request to enter self-refresh |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| cmd_ack | input | 1 | Command interface acknowledge |
| cke | output | 1 | DRAM clock-enable level |
| cmd_valid | output | 1 | Command request valid |
| cmd_op | output | 3 | Command code (PRE 0, REF 1, MRS 2, EMRS 3, SRE 4) |
| cmd_dll_rst | output | 1 | DLL-reset qualifier on MRS |
| ready | output | 1 | DRAM usable, normal traffic allowed |

## Verification
The assertions check several rules on every cycle:
- a stalled request is held steady;
- no request is made with CKE low;
- `ready` implies CKE high;
- CKE falling always drops `ready`;
- `ready` rises only right after the acknowledge of a REF or a final MRS without DLL reset.

Other behaviours only the bench scenarios can show. These are:
- the exact cold command order;
- the stabilization and exit-latency cycle counts;
- that a write with the wrong mode and init combination is ignored;
- the lock that makes warm writes ignored after the first exit, with the absence of mode-register loads on every warm exit.

// File: rtl/dws_pkg.sv
package dws_pkg;

    typedef enum logic [2:0] {
        CMD_PRE  = 3'd0,
        CMD_REF  = 3'd1,
        CMD_MRS  = 3'd2,
        CMD_EMRS = 3'd3,
        CMD_SRE  = 3'd4
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STAB,
        ST_PRE_A,
        ST_EMRS,
        ST_MRS_DLL,
        ST_PRE_B,
        ST_REF_A,
        ST_REF_B,
        ST_MRS_RUN,
        ST_READY,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_XWAIT,
        ST_XREF
    } seq_state_e;

    localparam logic [1:0] MODE_COLD = 2'b01;

endpackage

// File: rtl/dws_cfg_decode.sv
module dws_cfg_decode
    import dws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_init,
    input  logic       exit_done,
    output logic       cold_go,
    output logic       warm_go,
    output logic       warm_lock
);

    // Cold start needs the cold mode code and the init bit in one write.
    assign cold_go = cfg_we && (cfg_mode == MODE_COLD) && cfg_init;

    // Warm writes count only until the first completed self-refresh exit.
    assign warm_go = cfg_we && cfg_mode[1] && !warm_lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_lock <= 1'b0;
        end else if (exit_done) begin
            warm_lock <= 1'b1;
        end
    end

endmodule

// File: rtl/dws_delay.sv
module dws_delay #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dws_fsm.sv
module dws_fsm
    import dws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cold_go,
    input  logic       warm_go,
    input  logic       sr_enter_req,
    input  logic       sr_exit_req,
    input  logic       cmd_ack,
    input  logic       expired,
    output logic       cke,
    output logic       cmd_valid,
    output logic [2:0] cmd_op,
    output logic       cmd_dll_rst,
    output logic       ready,
    output logic       timer_clear,
    output logic       sel_exit,
    output logic       exit_done
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cold_go)      state_d = ST_STAB;
                else if (warm_go) state_d = ST_XWAIT;
            end
            ST_STAB:     if (expired) state_d = ST_PRE_A;
            ST_PRE_A:    if (cmd_ack) state_d = ST_EMRS;
            ST_EMRS:     if (cmd_ack) state_d = ST_MRS_DLL;
            ST_MRS_DLL:  if (cmd_ack) state_d = ST_PRE_B;
            ST_PRE_B:    if (cmd_ack) state_d = ST_REF_A;
            ST_REF_A:    if (cmd_ack) state_d = ST_REF_B;
            ST_REF_B:    if (cmd_ack) state_d = ST_MRS_RUN;
            ST_MRS_RUN:  if (cmd_ack) state_d = ST_READY;
            ST_READY: begin
                if (cold_go)           state_d = ST_STAB;
                else if (sr_enter_req) state_d = ST_SR_ENTER;
            end
            ST_SR_ENTER: if (cmd_ack) state_d = ST_SR_HOLD;
            ST_SR_HOLD:  if (sr_exit_req || warm_go) state_d = ST_XWAIT;
            ST_XWAIT:    if (expired) state_d = ST_XREF;
            ST_XREF:     if (cmd_ack) state_d = ST_READY;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cke         = 1'b1;
        cmd_valid   = 1'b0;
        cmd_op      = CMD_PRE;
        cmd_dll_rst = 1'b0;
        ready       = 1'b0;
        timer_clear = 1'b1;
        sel_exit    = 1'b0;
        exit_done   = 1'b0;
        unique case (state_q)
            ST_IDLE:    cke = 1'b0;
            ST_STAB: begin
                cke         = 1'b0;
                timer_clear = 1'b0;
            end
            ST_PRE_A, ST_PRE_B: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_PRE;
            end
            ST_EMRS: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_EMRS;
            end
            ST_MRS_DLL: begin
                cmd_valid   = 1'b1;
                cmd_op      = CMD_MRS;
                cmd_dll_rst = 1'b1;
            end
            ST_REF_A, ST_REF_B: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_REF;
            end
            ST_MRS_RUN: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_MRS;
            end
            ST_READY:   ready = 1'b1;
            ST_SR_ENTER: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_SRE;
            end
            ST_SR_HOLD: cke = 1'b0;
            ST_XWAIT: begin
                timer_clear = 1'b0;
                sel_exit    = 1'b1;
            end
            ST_XREF: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_REF;
                exit_done = cmd_ack;
            end
            default:    cke = 1'b0;
        endcase
    end

endmodule

// File: rtl/dram_wake_seq.sv
module dram_wake_seq
    import dws_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_init,
    input  logic [CNT_W-1:0] stab_cycles,
    input  logic [CNT_W-1:0] exit_cycles,
    input  logic             sr_enter_req,
    input  logic             sr_exit_req,
    input  logic             cmd_ack,
    output logic             cke,
    output logic             cmd_valid,
    output logic [2:0]       cmd_op,
    output logic             cmd_dll_rst,
    output logic             ready
);

    logic cold_go, warm_go, warm_lock;
    logic expired, timer_clear, sel_exit, exit_done;
    logic [CNT_W-1:0] limit;

    assign limit = sel_exit ? exit_cycles : stab_cycles;

    dws_cfg_decode u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_mode  (cfg_mode),
        .cfg_init  (cfg_init),
        .exit_done (exit_done),
        .cold_go   (cold_go),
        .warm_go   (warm_go),
        .warm_lock (warm_lock)
    );

    dws_delay #(.CNT_W(CNT_W)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .limit   (limit),
        .expired (expired)
    );

    dws_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cold_go      (cold_go),
        .warm_go      (warm_go),
        .sr_enter_req (sr_enter_req),
        .sr_exit_req  (sr_exit_req),
        .cmd_ack      (cmd_ack),
        .expired      (expired),
        .cke          (cke),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_dll_rst  (cmd_dll_rst),
        .ready        (ready),
        .timer_clear  (timer_clear),
        .sel_exit     (sel_exit),
        .exit_done    (exit_done)
    );

endmodule

// File: rtl/dws_checker.sv
module dws_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       ready,
    input logic       cmd_valid,
    input logic       cmd_ack,
    input logic [2:0] cmd_op,
    input logic       cmd_dll_rst
);

    p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_dll_rst)));

    p_req_with_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cke);

    p_ready_needs_cke_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cke);

    p_cke_drop_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> !ready);

    p_ready_after_last_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(cmd_valid && cmd_ack &&
            ((cmd_op == 3'd1) || (cmd_op == 3'd2 && !cmd_dll_rst))));

endmodule

bind dram_wake_seq dws_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke         (cke),
    .ready       (ready),
    .cmd_valid   (cmd_valid),
    .cmd_ack     (cmd_ack),
    .cmd_op      (cmd_op),
    .cmd_dll_rst (cmd_dll_rst)
);

// File: tb/sim_dram_wake_seq.sv
module sim_dram_wake_seq;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_we, cfg_init, sr_enter_req, sr_exit_req, cmd_ack;
    logic [1:0]       cfg_mode;
    logic [CNT_W-1:0] stab_cycles, exit_cycles;
    logic             cke, cmd_valid, cmd_dll_rst, ready;
    logic [2:0]       cmd_op;

    typedef struct {
        logic [2:0] op;
        logic       dll;
        string      req;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   fails   = 0;
    int   ack_lat = 0;

    always #5 clk = ~clk;

    dram_wake_seq #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_init(cfg_init), .stab_cycles(stab_cycles), .exit_cycles(exit_cycles),
        .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req), .cmd_ack(cmd_ack),
        .cke(cke), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dll_rst(cmd_dll_rst), .ready(ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    task automatic push(input logic [2:0] op, input logic dll, input string req);
        exp_t e;
        e.op = op; e.dll = dll; e.req = req;
        q.push_back(e);
    endtask

    task automatic push_cold(input string req);
        push(3'd0, 1'b0, req);
        push(3'd3, 1'b0, req);
        push(3'd2, 1'b1, req);
        push(3'd0, 1'b0, req);
        push(3'd1, 1'b0, req);
        push(3'd1, 1'b0, req);
        push(3'd2, 1'b0, req);
    endtask

    // Acknowledge responder: stalls ack_lat cycles, then acks one cycle.
    initial begin
        int wait_n;
        wait_n  = 0;
        cmd_ack = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (cmd_ack) begin
                cmd_ack = 1'b0;
            end else if (cmd_valid) begin
                if (wait_n >= ack_lat) begin
                    cmd_ack = 1'b1;
                    wait_n  = 0;
                end else begin
                    wait_n++;
                end
            end
        end
    end

    // Scoreboard monitor: compares each accepted request with the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid && cmd_ack) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected request", {cmd_op, cmd_dll_rst}, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cmd_op == e.op && cmd_dll_rst == e.dll, e.req,
                        "request op/dll", {cmd_op, cmd_dll_rst}, {e.op, e.dll});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", "run timed out", 0, 1);
        report();
        $finish;
    end

    task automatic cfg_write(input logic [1:0] m, input logic i);
        @(negedge clk);
        cfg_mode = m; cfg_init = i; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_mode = 2'b00; cfg_init = 1'b0;
    endtask

    task automatic pulse_enter();
        @(negedge clk); sr_enter_req = 1'b1;
        @(negedge clk); sr_enter_req = 1'b0;
    endtask

    task automatic pulse_exit();
        @(negedge clk); sr_exit_req = 1'b1;
        @(negedge clk); sr_exit_req = 1'b0;
    endtask

    task automatic measure_gap(input string req, input int expect_n, input logic cke_exp);
        int n;
        int bad;
        n = 0; bad = 0;
        while (!cmd_valid && n < 1000) begin
            if (cke !== cke_exp) bad++;
            n++;
            @(negedge clk);
        end
        chk(n == expect_n, req, "cycles before first request", n, expect_n);
        chk(bad == 0 && cke === 1'b1, req, "cke wrong during wait or at request", bad, 0);
    endtask

    task automatic wait_ready(input string req);
        int n;
        n = 0;
        while (!ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(ready === 1'b1 && cke === 1'b1, req, "ready with cke high", ready, 1);
        chk(q.size() == 0, req, "expected requests still pending", q.size(), 0);
    endtask

    task automatic quiet(input string req, input int n, input logic cke_exp);
        int bad;
        bad = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (cmd_valid || ready || cke !== cke_exp) bad++;
        end
        chk(bad == 0, req, "activity after ignored stimulus", bad, 0);
    endtask

    task automatic enter_sr(input string req);
        int n;
        n = 0;
        push(3'd4, 1'b0, req);
        pulse_enter();
        while (cke && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(cke === 1'b0 && ready === 1'b0, req, "cke/ready after SRE", {cke, ready}, 0);
        chk(q.size() == 0, req, "SRE request not seen", q.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_mode = 2'b00; cfg_init = 1'b0;
        sr_enter_req = 1'b0; sr_exit_req = 1'b0;
        stab_cycles = 8'd5; exit_cycles = 8'd3;
        repeat (3) @(negedge clk);
        chk(cke === 1'b0 && ready === 1'b0 && cmd_valid === 1'b0, "R1",
            "outputs in reset", {cke, ready, cmd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cke === 1'b0 && ready === 1'b0 && cmd_valid === 1'b0, "R1",
            "outputs after reset", {cke, ready, cmd_valid}, 0);

        // R2: wrong combinations start nothing
        cfg_write(2'b00, 1'b1);
        quiet("R2", 12, 1'b0);
        cfg_write(2'b01, 1'b0);
        quiet("R2", 12, 1'b0);

        // R3 / R4: cold path
        ack_lat = 2;
        push_cold("R4");
        cfg_write(2'b01, 1'b1);
        measure_gap("R3", 6, 1'b0);
        wait_ready("R7");

        // R8 then R5 warm write from self-refresh hold
        enter_sr("R8");
        ack_lat = 0;
        push(3'd1, 1'b0, "R5");
        cfg_write(2'b10, 1'b0);
        measure_gap("R5", 4, 1'b1);
        wait_ready("R5");

        // R10: lock set, warm write ignored
        enter_sr("R8");
        cfg_write(2'b11, 1'b0);
        quiet("R10", 15, 1'b0);

        // R9: exit request, exit latency 0
        exit_cycles = 8'd0;
        ack_lat = 3;
        push(3'd1, 1'b0, "R9");
        pulse_exit();
        measure_gap("R9", 1, 1'b1);
        wait_ready("R9");

        // R11: cold rerun from ready
        stab_cycles = 8'd2;
        ack_lat = 1;
        push_cold("R11");
        cfg_write(2'b01, 1'b1);
        chk(ready === 1'b0 && cke === 1'b0, "R11", "ready/cke after rerun trigger",
            {ready, cke}, 0);
        measure_gap("R11", 3, 1'b0);
        wait_ready("R11");

        // R1 again, then R5 from idle with init bit set (R2: init ignored)
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cke === 1'b0 && ready === 1'b0, "R1", "outputs after second reset",
            {cke, ready}, 0);
        exit_cycles = 8'd2;
        ack_lat = 0;
        push(3'd1, 1'b0, "R2");
        cfg_write(2'b11, 1'b1);
        measure_gap("R5", 3, 1'b1);
        wait_ready("R2");

        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule